// File: doc/BRIEF.md
# Interrupt Request Low-Gap Stretcher

This block sits on the wire between an interrupt controller's request output and a consumer that reacts only to rising edges, such as an interrupt router input or a processor interrupt pin. When a higher-priority request arrives just as an earlier, lower-priority request is being acknowledged, the controller may drop its request for only a few nanoseconds before raising it again. A consumer with a minimum low-time requirement can miss such a gap, and the second interrupt is then lost.

The guard synchronizes the raw request. It opens a hold window on any falling edge of the synchronized request, and also on any acknowledge strobe that arrives while the request is high. For the length of the window the output is forced low, so the downstream edge is always clean. The window length comes from a count input. When the window closes, the output takes the current request level: a request that came back during the window rises at once, and one that went away leaves the output low. A count of zero turns the guard into a plain registered pass-through.

Top module: `irq_lowgap_guard`

## Requirements
- R1: While reset is asserted, the output is low and no hold window is open.
- R2: With a count of 0, the output follows the request input with a latency of three clock edges (two synchronizer flops plus the output flop), and acknowledge strobes have no effect.
- R3: A request low gap that lasts at least one clock, as seen after the synchronizer, opens a hold window. The output goes low on the third clock edge after the edge that first samples the request low, even if the request has already returned high.
- R4: With a nonzero count N, the output stays low for N+1 consecutive cycles, starting with the cycle in which the window opens.
- R5: An acknowledge strobe (active high, synchronous to the clock, not synchronized) that is sampled while the synchronized request is high opens a hold window on that same clock edge, and the output goes low.
- R6: An acknowledge strobe that is sampled while the synchronized request is low, with no window open, has no effect on later output timing.
- R7: A request that is high when the window ends drives the output high on the first clock edge after the last held cycle.
- R8: A request that is low when the window ends leaves the output low.
- R9: A new falling edge or a qualifying acknowledge during an open window reloads the window with the full count, which extends the low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Raw interrupt request from the controller, asynchronous |
| ack_in | input | 1 | Acknowledge strobe, synchronous, active high |
| min_low | input | CNT_W | Hold window length in clocks; 0 selects pass-through |
| irq_out | output | 1 | Guarded request to the edge-sensitive consumer |

## Verification
The request is driven with steady levels in pass-through mode, with single-clock gaps, and with two gaps close together. This separates a correct window length from a window that is off by one, and separates reloading from ignoring a second trigger. An acknowledge is applied once with the request high and once with it low, which shows whether the strobe is qualified by the request level. A gap followed by a request that stays low shows that the output is not re-armed from a stale level. Window lengths of 1, 5 and 300 exercise the smallest and a long countdown.

// File: rtl/irq_lowgap_guard.sv
module irq_lowgap_guard #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  input  logic             ack_in,
  input  logic [CNT_W-1:0] min_low,
  output logic             irq_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s, req_d;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   fall, ack_hit, arm, holding;

  assign req_s   = sync_q[SYNC_STAGES-1];
  assign fall    = req_d & ~req_s;
  assign ack_hit = ack_in & req_s;
  assign arm     = (fall | ack_hit) && (min_low != '0);
  assign holding = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      req_d    <= 1'b0;
      hold_cnt <= '0;
      irq_out  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
      req_d  <= req_s;
      if (arm) begin
        hold_cnt <= min_low;
        irq_out  <= 1'b0;
      end else if (holding) begin
        hold_cnt <= hold_cnt - CNT_W'(1);
        irq_out  <= 1'b0;
      end else begin
        irq_out  <= req_s;
      end
    end
  end

  AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> !irq_out); // R4

  AST_LOAD_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (hold_cnt == $past(min_low))); // R9

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !arm) |=> (hold_cnt == CNT_W'($past(hold_cnt) - CNT_W'(1)))); // R4

  AST_RISE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(hold_cnt) == '0 && $past(req_s))); // R7

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && !arm) |=> (irq_out == $past(req_s))); // R2

  AST_ACK_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !req_s && !fall && !holding) |=> (hold_cnt == '0)); // R6

endmodule

// File: tb/test_irq_lowgap_guard.sv
module test_irq_lowgap_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_in = 1'b0;
  logic        ack_in = 1'b0;
  logic [15:0] min_low = '0;
  logic        irq_out;

  irq_lowgap_guard i_irq_lowgap_guard (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in),
    .min_low(min_low), .irq_out(irq_out));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int c; bit v; string tag; } exp_t;
  exp_t q[$];

  task automatic expect_at(int c, bit v, string tag);
    exp_t e;
    int i = 0;
    e.c = c; e.v = v; e.tag = tag;
    while (i < q.size() && q[i].c <= c) i++;
    q.insert(i, e);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    while (q.size() > 0) tick(1);
    tick(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].c <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.c != cyc || irq_out !== e.v) begin
          errors++;
          $display("FAIL %s cyc %0d: irq_out=%b expected %b", e.tag, e.c, irq_out, e.v);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    int k;
    tick(3);
    checks++;
    if (irq_out !== 1'b0) begin errors++; $display("FAIL R1 reset: irq_out=%b expected 0", irq_out); end
    rst_n = 1'b1;
    tick(2);
    checks++;
    if (irq_out !== 1'b0) begin errors++; $display("FAIL R1 after reset: irq_out=%b expected 0", irq_out); end

    // R2 pass-through with count 0
    req_in = 1'b1; k = cyc;
    expect_at(k + 2, 1'b0, "R2 latency");
    expect_at(k + 3, 1'b1, "R2 rise");
    tick(5);
    req_in = 1'b0; k = cyc;
    expect_at(k + 3, 1'b0, "R2 gap low");
    expect_at(k + 4, 1'b1, "R2 gap high");
    tick(1); req_in = 1'b1;
    tick(4);
    ack_in = 1'b1; k = cyc;
    expect_at(k + 1, 1'b1, "R2 ack ignored");
    expect_at(k + 2, 1'b1, "R2 ack ignored");
    tick(1); ack_in = 1'b0;
    drain();

    // R3 R4 R7 one-clock gap, count 5
    min_low = 16'd5;
    tick(2);
    req_in = 1'b0; k = cyc;
    expect_at(k + 2, 1'b1, "R3 before");
    for (int i = 3; i <= 8; i++) expect_at(k + i, 1'b0, "R4 held");
    expect_at(k + 9, 1'b1, "R7 release");
    tick(1); req_in = 1'b1;
    drain();

    // R5 acknowledge with request high
    ack_in = 1'b1; k = cyc;
    expect_at(k, 1'b1, "R5 before");
    for (int i = 1; i <= 6; i++) expect_at(k + i, 1'b0, "R5 held");
    expect_at(k + 7, 1'b1, "R5 release");
    tick(1); ack_in = 1'b0;
    drain();

    // R9 second gap during hold reloads
    req_in = 1'b0; k = cyc;
    for (int i = 3; i <= 11; i++) expect_at(k + i, 1'b0, "R9 extended");
    expect_at(k + 12, 1'b1, "R9 release");
    tick(1); req_in = 1'b1;
    tick(2); req_in = 1'b0;
    tick(1); req_in = 1'b1;
    drain();

    // R8 request gone at end of hold
    req_in = 1'b0; k = cyc;
    for (int i = 3; i <= 16; i++) expect_at(k + i, 1'b0, "R8 stays low");
    tick(1); req_in = 1'b1;
    tick(2); req_in = 1'b0;
    drain();

    // R6 acknowledge with request low
    ack_in = 1'b1; k = cyc;
    expect_at(k + 3, 1'b0, "R6 before");
    expect_at(k + 4, 1'b1, "R6 no hold");
    tick(1); ack_in = 1'b0; req_in = 1'b1;
    drain();

    // R4 boundary count 1
    min_low = 16'd1;
    tick(2);
    req_in = 1'b0; k = cyc;
    expect_at(k + 3, 1'b0, "R4 n1");
    expect_at(k + 4, 1'b0, "R4 n1");
    expect_at(k + 5, 1'b1, "R7 n1 release");
    tick(1); req_in = 1'b1;
    drain();

    // R4 long count 300
    min_low = 16'd300;
    tick(2);
    req_in = 1'b0; k = cyc;
    expect_at(k + 3, 1'b0, "R4 n300 start");
    expect_at(k + 150, 1'b0, "R4 n300 mid");
    expect_at(k + 303, 1'b0, "R4 n300 last");
    expect_at(k + 304, 1'b1, "R7 n300 release");
    tick(1); req_in = 1'b1;
    drain();

    finish_run();
  end
endmodule